// File: doc/BRIEF.md
# Serial TDM System Bus Frame Timebase

This block keeps track of where a serial time-division bus currently is within its frame. The bus clock reaches the block as an ordinary input and is sampled by a faster core clock. The block picks out one edge of the bus clock and uses it to step a bit counter. From the bit counter it derives a time-slot index. The frame is either 193 bits long, as one framing bit followed by 24 eight-bit slots, or 256 bits long, as 32 eight-bit slots.

The sync logic and the data logic each choose their own bus clock edge, rising or falling. In double-rate operation each edge stream is divided by two before use. The frame sync pin can work in either direction. As an output, it is high for one bus bit while the counter sits at a programmed offset bit. As an input, a rising level on the pin loads the counter with that offset. When the pulses stop, the counter carries on with the frame period on its own. A frame-start strobe marks each wrap of the counter to bit zero. A data strobe marks each selected data edge, for use by the bus data path.

Top module: `sbus_timebase`

## Requirements
- R1: While rst_n is low at a clk edge, and after that edge, bit_idx = 0, slot_idx = 0, sync_oe = 0 (sync pin direction input), sync_out = 0 and frame_start = 0.
- R2: bit_idx advances by one on each selected sync edge of bus_clk (cfg_sync_fall = 0 selects the low-to-high transition, 1 selects high-to-low). It wraps from 192 to 0 when cfg_e1 = 0, and from 255 to 0 when cfg_e1 = 1.
- R3: When cfg_dbl = 1, bit_idx advances once for every two selected sync edges. The first selected edge after reset is the one that is skipped.
- R4: slot_idx is bit_idx / 8 when cfg_e1 = 1. When cfg_e1 = 0, slot_idx is 0 at bit 0 (the framing bit) and (bit_idx - 1) / 8 otherwise.
- R5: frame_start is high for exactly one clk cycle each time bit_idx wraps from the last bit to 0 by counting. A load caused by the sync input does not raise it.
- R6: With sync_oe = 1, sync_out is high exactly while bit_idx equals the normalized offset. With sync_oe = 0, sync_out stays 0.
- R7: With sync_oe = 0, a selected sync edge at which sync_in is 1 loads bit_idx with the normalized offset, provided sync_in was 0 at the previous selected sync edge. A level that stays high, a falling level, and any sync_in activity while sync_oe = 1 have no effect on counting.
- R8: After the last sync input pulse, bit_idx keeps counting and wrapping with the frame length of R2.
- R9: The normalized offset is cfg_offset modulo the frame length. For example, 400 gives 14 for a 193-bit frame, and 300 gives 44 for a 256-bit frame.
- R10: data_tick pulses for one clk cycle on each selected data edge of bus_clk (cfg_data_fall, encoded like cfg_sync_fall), independently of the sync edge choice. In double-rate mode it pulses on every second such edge, and the first edge after reset is skipped.
- R11: A clk cycle with dir_load = 1 copies dir_out into sync_oe (1 = output). Without dir_load, sync_oe holds its value whatever dir_out does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than twice the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock, sampled by clk |
| sync_in | input | 1 | Frame sync pin level, used when the pin is an input |
| cfg_e1 | input | 1 | 0: 193-bit frame, 1: 256-bit frame |
| cfg_dbl | input | 1 | 1: bus clock runs at twice the bit rate |
| cfg_data_fall | input | 1 | Data edge select, 1 = falling |
| cfg_sync_fall | input | 1 | Sync and counter edge select, 1 = falling |
| cfg_offset | input | 9 | Programmed offset bit position |
| dir_load | input | 1 | Strobe that captures dir_out |
| dir_out | input | 1 | Requested sync pin direction, 1 = output |
| sync_out | output | 1 | Frame sync output pulse |
| sync_oe | output | 1 | Current sync pin direction, 1 = output |
| data_tick | output | 1 | One-cycle strobe per selected data edge |
| bit_idx | output | 9 | Current bit position within the frame |
| slot_idx | output | 5 | Current time-slot index |
| frame_start | output | 1 | One-cycle strobe when the counter wraps to 0 |

## Verification
The hardest situation to reach from the ports is a sync input rising edge while the clock is halved, combined with an offset that must be reduced more than once. The counter only sees every second sampled edge, so a sync pulse that is too short can fall between the edges that count. The stimulus holds each sync_in level for a random number of bus edges. It also programs offsets near the top of the 9-bit range in 193-bit mode, where two subtractions are needed. Long quiet stretches then show that the counter keeps its phase after the pulses stop.

// File: rtl/sbus_pkg.sv
// Shared widths and frame lengths for the serial bus timebase.
// Assumes both frame lengths fit in POS_W bits.
package sbus_pkg;
    localparam int unsigned POS_W   = 9;
    localparam int unsigned SLOT_W  = 5;
    localparam int unsigned T1_BITS = 193;
    localparam int unsigned E1_BITS = 256;
    typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/sbus_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes each input level lasts longer than STAGES clk cycles.
module sbus_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    // shift the pin levels through the synchronizing stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sbus_edge_tick.sv
// Selects the rising or falling edge of a synchronized bus clock and
// optionally halves the edge stream for double-rate buses.
// Assumes the pin toggles no faster than every second clk cycle.
module sbus_edge_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic use_fall,
    input  logic halve,
    output logic tick
);
    logic pin_q;
    logic phase;
    logic hit;

    // edge of the chosen polarity
    always_comb hit = use_fall ? (pin_q & ~pin) : (pin & ~pin_q);

    // pass every edge, or every second edge when halving
    always_comb tick = hit & (~halve | phase);

    // previous pin level and divide-by-two phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            phase <= 1'b0;
        end else begin
            pin_q <= pin;
            if (hit) phase <= ~phase;
        end
    end
endmodule

// File: rtl/sbus_offset_norm.sv
// Reduces the programmed offset modulo the active frame length by
// repeated conditional subtraction.
// Assumes the shorter frame is no longer than 2**POS_W.
module sbus_offset_norm #(
    parameter int unsigned POS_W   = 9,
    parameter int unsigned T1_BITS = 193,
    parameter int unsigned E1_BITS = 256
) (
    input  logic             e1,
    input  logic [POS_W-1:0] raw,
    output logic [POS_W-1:0] norm
);
    localparam int unsigned MAX_SUB = ((2 ** POS_W) - 1) / T1_BITS;

    logic [POS_W-1:0] len;
    logic [POS_W-1:0] v;

    // conditional subtraction chain bounded by the worst-case quotient
    always_comb begin
        len = e1 ? POS_W'(E1_BITS) : POS_W'(T1_BITS);
        v   = raw;
        for (int i = 0; i < MAX_SUB; i++) begin
            if (v >= len) v = v - len;
        end
        norm = v;
    end
endmodule

// File: rtl/sbus_pos_counter.sv
// Bit position counter with load, wrap strobe and slot decode.
// Assumes tick and load are single clk-cycle qualifiers.
module sbus_pos_counter #(
    parameter int unsigned POS_W   = 9,
    parameter int unsigned SLOT_W  = 5,
    parameter int unsigned T1_BITS = 193,
    parameter int unsigned E1_BITS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [POS_W-1:0]  load_val,
    input  logic              e1,
    output logic [POS_W-1:0]  pos,
    output logic [SLOT_W-1:0] slot,
    output logic              wrap
);
    logic [POS_W-1:0] last;

    // final bit index of the active frame
    always_comb last = e1 ? POS_W'(E1_BITS - 1) : POS_W'(T1_BITS - 1);

    // count, load from sync, and flag a counted wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            wrap <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (tick) begin
                if (load) begin
                    pos <= load_val;
                end else if (pos >= last) begin
                    pos  <= '0;
                    wrap <= 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    // slot index, skipping the leading framing bit in 193-bit frames
    always_comb begin
        if (e1) slot = SLOT_W'(pos >> 3);
        else if (pos == '0) slot = '0;
        else slot = SLOT_W'((pos - 1'b1) >> 3);
    end
endmodule

// File: rtl/sbus_timebase.sv
// Frame timebase for a serial TDM system bus: edge selection, optional
// clock halving, bidirectional frame sync with offset alignment, and
// free-running position counters.
// Assumes clk is more than twice as fast as bus_clk.
module sbus_timebase
    import sbus_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic              sync_in,
    input  logic              cfg_e1,
    input  logic              cfg_dbl,
    input  logic              cfg_data_fall,
    input  logic              cfg_sync_fall,
    input  logic [POS_W-1:0]  cfg_offset,
    input  logic              dir_load,
    input  logic              dir_out,
    output logic              sync_out,
    output logic              sync_oe,
    output logic              data_tick,
    output logic [POS_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              frame_start
);
    logic [1:0] pins_s;
    logic       bclk_s;
    logic       sync_s;
    logic       sync_tick;
    logic       sync_prev;
    logic       dir_q;
    logic       load;
    pos_t       offs_norm;

    sbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sync_in, bus_clk}), .q(pins_s)
    );
    assign bclk_s = pins_s[0];
    assign sync_s = pins_s[1];

    sbus_edge_tick u_sync_edge (
        .clk(clk), .rst_n(rst_n), .pin(bclk_s),
        .use_fall(cfg_sync_fall), .halve(cfg_dbl), .tick(sync_tick)
    );

    sbus_edge_tick u_data_edge (
        .clk(clk), .rst_n(rst_n), .pin(bclk_s),
        .use_fall(cfg_data_fall), .halve(cfg_dbl), .tick(data_tick)
    );

    sbus_offset_norm #(.POS_W(POS_W), .T1_BITS(T1_BITS), .E1_BITS(E1_BITS)) u_norm (
        .e1(cfg_e1), .raw(cfg_offset), .norm(offs_norm)
    );

    // sync pin level seen at the previous counting edge
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev <= 1'b0;
        else if (sync_tick) sync_prev <= sync_s;
    end

    // sync pin direction register
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= 1'b0;
        else if (dir_load) dir_q <= dir_out;
    end

    // low-to-high sync input in input mode realigns the counter
    always_comb load = ~dir_q & sync_s & ~sync_prev;

    sbus_pos_counter #(
        .POS_W(POS_W), .SLOT_W(SLOT_W), .T1_BITS(T1_BITS), .E1_BITS(E1_BITS)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(sync_tick), .load(load),
        .load_val(offs_norm), .e1(cfg_e1), .pos(bit_idx), .slot(slot_idx),
        .wrap(frame_start)
    );

    // output sync marks the offset bit for one bus bit
    always_comb sync_out = dir_q & (bit_idx == offs_norm);
    assign sync_oe = dir_q;
endmodule

// File: rtl/sbus_timebase_chk.sv
// Property checker for the bus timebase, bound to its top module.
// Assumes the bus clock is slower than half the core clock.
module sbus_timebase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_e1,
    input logic       dir_load,
    input logic       sync_out,
    input logic       sync_oe,
    input logic       data_tick,
    input logic [8:0] bit_idx,
    input logic [4:0] slot_idx,
    input logic       frame_start
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (bit_idx == 9'd0 && !sync_oe && !frame_start));

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r5_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> bit_idx == 9'd0);

    a_r6_quiet_input: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_oe |-> !sync_out);

    a_r4_fbit_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_e1 && bit_idx == 9'd0) |-> slot_idx == 5'd0);

    a_r4_e1_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_e1 && bit_idx == 9'd255) |-> slot_idx == 5'd31);

    a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        data_tick |=> !data_tick);

    a_r11_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_load |=> $stable(sync_oe));
endmodule

bind sbus_timebase sbus_timebase_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_e1(cfg_e1), .dir_load(dir_load),
    .sync_out(sync_out), .sync_oe(sync_oe), .data_tick(data_tick),
    .bit_idx(bit_idx), .slot_idx(slot_idx), .frame_start(frame_start)
);

// File: tb/test_sbus_timebase.sv
module test_sbus_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_clk = 1'b0;
    logic       sync_in = 1'b0;
    logic       cfg_e1 = 1'b0;
    logic       cfg_dbl = 1'b0;
    logic       cfg_data_fall = 1'b0;
    logic       cfg_sync_fall = 1'b0;
    logic [8:0] cfg_offset = 9'd0;
    logic       dir_load = 1'b0;
    logic       dir_out = 1'b0;
    logic       sync_out;
    logic       sync_oe;
    logic       data_tick;
    logic [8:0] bit_idx;
    logic [4:0] slot_idx;
    logic       frame_start;

    sbus_timebase i_sbus_timebase (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .sync_in(sync_in),
        .cfg_e1(cfg_e1), .cfg_dbl(cfg_dbl), .cfg_data_fall(cfg_data_fall),
        .cfg_sync_fall(cfg_sync_fall), .cfg_offset(cfg_offset),
        .dir_load(dir_load), .dir_out(dir_out), .sync_out(sync_out),
        .sync_oe(sync_oe), .data_tick(data_tick), .bit_idx(bit_idx),
        .slot_idx(slot_idx), .frame_start(frame_start)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int fs_cnt = 0;
    int dt_cnt = 0;
    int fs_base, dt_base;
    int m_bit, m_frames, m_dticks;
    bit m_phs, m_phd, m_sprev, m_dir, m_bclk;

    // strobe monitors
    always @(posedge clk) begin
        if (rst_n && frame_start) fs_cnt <= fs_cnt + 1;
        if (rst_n && data_tick) dt_cnt <= dt_cnt + 1;
    end

    function automatic int flen(bit e1);
        return e1 ? 256 : 193;
    endfunction

    function automatic int norm_off(int off, bit e1);
        return off % flen(e1);
    endfunction

    function automatic int slot_of(int b, bit e1);
        if (e1) return b / 8;
        if (b == 0) return 0;
        return (b - 1) / 8;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_clk = 1'b0; sync_in = 1'b0; dir_load = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_bit = 0; m_frames = 0; m_dticks = 0;
        m_phs = 0; m_phd = 0; m_sprev = 0; m_dir = 0; m_bclk = 0;
        repeat (2) @(negedge clk);
        fs_base = fs_cnt; dt_base = dt_cnt;
    endtask

    task automatic set_dir(bit v);
        @(negedge clk);
        dir_out = v; dir_load = 1'b1;
        @(negedge clk);
        dir_load = 1'b0;
        m_dir = v;
    endtask

    // one bus clock half period, with model update and checks
    task automatic half(string req);
        bit nv, s_sel, d_sel;
        nv = ~m_bclk;
        @(negedge clk);
        bus_clk = nv;
        s_sel = cfg_sync_fall ? (m_bclk && !nv) : (!m_bclk && nv);
        d_sel = cfg_data_fall ? (m_bclk && !nv) : (!m_bclk && nv);
        if (s_sel) begin
            if (!cfg_dbl || m_phs) begin
                if (!m_dir && sync_in && !m_sprev) m_bit = norm_off(int'(cfg_offset), cfg_e1);
                else if (m_bit >= flen(cfg_e1) - 1) begin m_bit = 0; m_frames++; end
                else m_bit++;
                m_sprev = sync_in;
            end
            m_phs = ~m_phs;
        end
        if (d_sel) begin
            if (!cfg_dbl || m_phd) m_dticks++;
            m_phd = ~m_phd;
        end
        m_bclk = nv;
        repeat (6) @(negedge clk);
        check(req, int'(bit_idx), m_bit);
        check("R4", int'(slot_idx), slot_of(m_bit, cfg_e1));
        check("R6", int'(sync_out),
              (m_dir && m_bit == norm_off(int'(cfg_offset), cfg_e1)) ? 1 : 0);
    endtask

    task automatic check_counts();
        check("R5", fs_cnt - fs_base, m_frames);
        check("R10", dt_cnt - dt_base, m_dticks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1 actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1: reset state, sampled during reset and after release
        repeat (3) @(negedge clk);
        check("R1", int'(bit_idx), 0);
        check("R1", int'(sync_oe), 0);
        do_reset();
        check("R1", int'(bit_idx), 0);
        check("R1", int'(slot_idx), 0);
        check("R1", int'(sync_out), 0);
        check("R1", int'(frame_start), 0);

        // R11: direction capture, then dir_out alone has no effect
        set_dir(1'b1);
        check("R11", int'(sync_oe), 1);
        @(negedge clk); dir_out = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", int'(sync_oe), 1);

        // R2, R6: 193-bit frame, rising edges, output sync at offset 5
        cfg_e1 = 0; cfg_sync_fall = 0; cfg_data_fall = 0; cfg_dbl = 0;
        cfg_offset = 9'd5;
        for (int i = 0; i < 420; i++) half("R2");
        check_counts();

        // R2, R9, R7: 256-bit frame, falling edges, offset 300 -> 44,
        // sync input toggled while in output mode has no effect
        do_reset();
        set_dir(1'b1);
        cfg_e1 = 1; cfg_sync_fall = 1; cfg_data_fall = 0; cfg_offset = 9'd300;
        for (int i = 0; i < 560; i++) begin
            if (i % 37 == 3) sync_in = ~sync_in;
            half("R7");
        end
        check_counts();

        // R3, R10: double rate, data edge differs from sync edge
        do_reset();
        sync_in = 0;
        cfg_e1 = 0; cfg_dbl = 1; cfg_sync_fall = 0; cfg_data_fall = 1;
        cfg_offset = 9'd0;
        for (int i = 0; i < 820; i++) half("R3");
        check_counts();

        // R7, R8: input mode, offset 300 in 256-bit frame, pulses then flywheel
        do_reset();
        cfg_e1 = 1; cfg_dbl = 0; cfg_sync_fall = 0; cfg_data_fall = 0;
        cfg_offset = 9'd300;
        for (int i = 0; i < 30; i++) half("R7");
        sync_in = 1;
        half("R7");
        check("R7", int'(bit_idx), 44);
        for (int i = 0; i < 100; i++) half("R7");
        sync_in = 0;
        for (int i = 0; i < 51; i++) half("R7");
        sync_in = 1;
        for (int i = 0; i < 40; i++) half("R7");
        sync_in = 0;
        for (int i = 0; i < 700; i++) half("R8");
        check_counts();

        // R9, R3: 193-bit frame, offset 400 -> 14, halved clock, input sync
        do_reset();
        cfg_e1 = 0; cfg_dbl = 1; cfg_sync_fall = 1; cfg_offset = 9'd400;
        for (int i = 0; i < 9; i++) half("R9");
        sync_in = 1;
        for (int i = 0; i < 8; i++) half("R9");
        sync_in = 0;
        for (int i = 0; i < 900; i++) half("R9");
        check_counts();

        // R8, R7: random configurations, directions and sync activity
        for (int r = 0; r < 5; r++) begin
            do_reset();
            cfg_e1 = 1'($urandom % 2);
            cfg_dbl = 1'($urandom % 2);
            cfg_sync_fall = 1'($urandom % 2);
            cfg_data_fall = 1'($urandom % 2);
            cfg_offset = 9'($urandom % 512);
            if (r == 4) cfg_offset = 9'd511;
            set_dir(1'($urandom % 2));
            for (int i = 0; i < 600; i++) begin
                if ($urandom % 40 == 0) sync_in = ~sync_in;
                half("R8");
            end
            check_counts();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule